// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block is a time-of-day and calendar counter chain advanced by a 100 Hz tick enable. It keeps a hundredths counter, seconds, minutes, hours with a 12-hour or 24-hour mode and a PM flag, day of month, a free-running weekday, month, a two-digit year and a two-bit leap counter. Every counter is an independent roll-over counter that carries into the next one when it wraps. The weekday and the leap counter are never derived from the date: each only steps when the field below it carries.

Software sees the clock as sixteen 4-bit registers selected by a register index, which is taken from bits 5:2 of a word-spaced byte address. Each time and date field is shown as two registers, one for its tens digit and one for its units digit. Writing one digit leaves the other digit of the same field as it was. A control/status register reports a data-changed flag, which is cleared when the register is read. Writing the same register stops or restarts counting. A clock-setting register holds the hour mode, the PM flag and the leap counter.

A small state machine holds the run state. It has two states. RUN_ST means ticks advance the chain, and HALT_ST means ticks are ignored. A control write with bit 2 set takes RUN_ST to HALT_ST. A control write with bit 2 clear takes HALT_ST to RUN_ST. Any other cycle keeps the current state.

Top module: `bcd_rtc`

## Requirements
- R1: While running, each cycle with the tick high and no write increments the hundredths counter. On the step past 99 it returns to 0, sets the data-changed flag and increments seconds.
- R2: Seconds and minutes each count 0 to 59. The step past 59 returns the field to 0 and increments the next field (seconds into minutes, minutes into hours).
- R3: With clock-setting bit 0 equal to 0 (12-hour mode), hours run 1 to 12. The step past 12 gives 1. PM (clock-setting bit 1) toggles whenever the hour becomes 12. The day advances only when the hour becomes 12 while PM was 1.
- R4: With clock-setting bit 0 equal to 1 (24-hour mode), hours run 0 to 23. The step past 23 gives 0 and advances the day.
- R5: Every day advance increments the weekday, and 7 steps to 1. A weekday write keeps only written bits 2:0.
- R6: Day of month steps past its month length to 1. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the leap counter is 0 and 28 days otherwise. Every other month value has 31 days.
- R7: When the day wraps to 1, the month increments. The step past 12 gives 1. On that step the leap counter increments modulo 4 (it is read back in clock-setting bits 3:2), and the year increments with 99 stepping to 0.
- R8: Register index map: 0 control/status, 1 tenths of second (hundredths divided by 10), 2/3 seconds units/tens, 4/5 minutes units/tens, 6/7 hours units/tens, 8/9 day units/tens, 10/11 month units/tens, 12/13 year units/tens, 14 weekday, 15 clock-setting. A digit register reads field%10 or field/10 (low 4 bits). After reset every register reads 0 and the clock is running.
- R9: A units-digit write sets the field to tens*10 + value. A tens-digit write sets it to value*10 + units. A tenths write sets the hundredths counter to value*10.
- R10: A control/status read returns the data-changed flag in bit 2 (other bits 0) and clears it, unless the same cycle sets it.
- R11: A control write with bit 2 set stops counting and clears the hundredths counter, and ticks are then ignored. A control write with bit 2 clear resumes counting.
- R12: A clock-setting write loads bit 0 as the mode, bit 1 as PM and bits 3:2 as the leap counter. In 24-hour mode PM is forced to 0 and reads 0.
- R13: A cycle with a register write performs no tick advance, even if the tick is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100hz | input | 1 | One-cycle 100 Hz advance enable |
| bus_word | input | 4 | Register index (byte address bits 5:2) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect on control/status only) |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for the selected register, combinational |

## Verification
A wrong count, a wrong carry or a wrong month length shows up in a digit register on the first cycle after the faulty edge. The reference model is compared with the read port on every clock, so the error is caught at once whenever the register index points at the affected field. Carries above the minutes happen rarely, so the directed cases preload fields to one tenth of a second before each boundary. This makes every hour, day, month and year wrap appear within ten ticks, where a full sweep of all sixteen registers exposes it. A stuck flag or a run state that does not change is seen on the next read of the control register or tenths register.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int FW      = 8;   // binary width of each time field
    localparam int DIGIT_W = 4;   // width of one BCD digit / bus word
    localparam int IDX_W   = 4;   // register index width
    localparam int NREG    = 1 << IDX_W;

    localparam int CTL_STOP_BIT = 2;
    localparam int CTL_CHG_BIT  = 2;

    typedef enum logic {
        RUN_ST  = 1'b0,
        HALT_ST = 1'b1
    } run_state_e;

    typedef enum logic [IDX_W-1:0] {
        RI_CTRL   = 4'd0,
        RI_TENTHS = 4'd1,
        RI_SEC_U  = 4'd2,
        RI_SEC_T  = 4'd3,
        RI_MIN_U  = 4'd4,
        RI_MIN_T  = 4'd5,
        RI_HR_U   = 4'd6,
        RI_HR_T   = 4'd7,
        RI_DAY_U  = 4'd8,
        RI_DAY_T  = 4'd9,
        RI_MON_U  = 4'd10,
        RI_MON_T  = 4'd11,
        RI_YR_U   = 4'd12,
        RI_YR_T   = 4'd13,
        RI_WDAY   = 4'd14,
        RI_CSET   = 4'd15
    } reg_idx_e;

    function automatic logic [FW-1:0] month_days(input logic [FW-1:0] mon,
                                                 input logic [1:0]    leap);
        logic [FW-1:0] len;
        case (mon)
            8'd2:                    len = (leap == 2'd0) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: len = 8'd30;
            default:                 len = 8'd31;
        endcase
        return len;
    endfunction

    function automatic logic [DIGIT_W-1:0] tens_of(input logic [FW-1:0] v);
        return DIGIT_W'(v / 8'd10);
    endfunction

    function automatic logic [DIGIT_W-1:0] units_of(input logic [FW-1:0] v);
        return DIGIT_W'(v % 8'd10);
    endfunction

    function automatic logic [FW-1:0] put_units(input logic [FW-1:0] v,
                                                input logic [DIGIT_W-1:0] d);
        return ((v / 8'd10) * 8'd10) + FW'(d);
    endfunction

    function automatic logic [FW-1:0] put_tens(input logic [FW-1:0] v,
                                               input logic [DIGIT_W-1:0] d);
        return (FW'(d) * 8'd10) + (v % 8'd10);
    endfunction

endpackage

// File: rtl/rtc_run_fsm.sv
module rtc_run_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic stop_req,
    output logic running
);

    run_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_ST:  if (ctrl_wr && stop_req)  state_d = HALT_ST;
            HALT_ST: if (ctrl_wr && !stop_req) state_d = RUN_ST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RUN_ST;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RUN_ST:  running = 1'b1;
            HALT_ST: running = 1'b0;
        endcase
    end

    // R11: stop request halts counting from the next cycle
    a_r11_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && stop_req) |=> !running);
    // R11: clear stop bit resumes counting
    a_r11_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !stop_req) |=> running);

endmodule

// File: rtl/rtc_wrap_ctr.sv
module rtc_wrap_ctr
    import rtc_pkg::*;
#(
    parameter int MAX = 59
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    input  logic               wr_units,
    input  logic               wr_tens,
    input  logic [DIGIT_W-1:0] wdigit,
    output logic [FW-1:0]      value,
    output logic               carry
);

    localparam logic [FW:0] LIM = (FW+1)'(MAX);

    logic [FW:0] nxt;
    assign nxt   = {1'b0, value} + (FW+1)'(1);
    assign carry = inc && (nxt > LIM);

    always_ff @(posedge clk) begin
        if (!rst_n)        value <= '0;
        else if (wr_units) value <= put_units(value, wdigit);
        else if (wr_tens)  value <= put_tens(value, wdigit);
        else if (inc)      value <= carry ? '0 : nxt[FW-1:0];
    end

    // R2: the field returns to zero on the step past its limit
    a_r2_field_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_units && !wr_tens && value == LIM[FW-1:0]) |=> value == '0);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int HR12_MAX = 12,
    parameter int HR24_MAX = 23,
    parameter int WDAY_MAX = 7,
    parameter int MON_MAX  = 12,
    parameter int YEAR_MAX = 99
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hour_inc,
    input  logic               wr_hr_u,
    input  logic               wr_hr_t,
    input  logic               wr_day_u,
    input  logic               wr_day_t,
    input  logic               wr_mon_u,
    input  logic               wr_mon_t,
    input  logic               wr_yr_u,
    input  logic               wr_yr_t,
    input  logic               wr_wday,
    input  logic               wr_cset,
    input  logic [DIGIT_W-1:0] wdata,
    output logic [FW-1:0]      hour,
    output logic [FW-1:0]      day,
    output logic [FW-1:0]      mon,
    output logic [FW-1:0]      year,
    output logic [2:0]         wday,
    output logic               pm,
    output logic               mode24,
    output logic [1:0]         leap
);

    localparam logic [FW:0] H12_LIM = (FW+1)'(HR12_MAX);
    localparam logic [FW:0] H24_LIM = (FW+1)'(HR24_MAX);
    localparam logic [FW:0] MON_LIM = (FW+1)'(MON_MAX);
    localparam logic [FW:0] YR_LIM  = (FW+1)'(YEAR_MAX);
    localparam logic [3:0]  WD_LIM  = 4'(WDAY_MAX);

    logic [FW:0]   hr_n, day_n, mon_n, yr_n;
    logic [3:0]    wd_n;
    logic [FW-1:0] hour_d, mlen;
    logic          pm_d, day_adv, day_wrap, mon_wrap, yr_wrap;
    logic          day_evt, mon_evt;

    assign hr_n  = {1'b0, hour} + (FW+1)'(1);
    assign day_n = {1'b0, day}  + (FW+1)'(1);
    assign mon_n = {1'b0, mon}  + (FW+1)'(1);
    assign yr_n  = {1'b0, year} + (FW+1)'(1);
    assign wd_n  = {1'b0, wday} + 4'd1;
    assign mlen  = month_days(mon, leap);

    // hour step and midnight detection per mode
    always_comb begin
        hour_d  = hr_n[FW-1:0];
        pm_d    = pm;
        day_adv = 1'b0;
        if (mode24) begin
            if (hr_n > H24_LIM) begin
                hour_d  = '0;
                day_adv = 1'b1;
            end
        end else begin
            if (hr_n == H12_LIM) begin
                pm_d    = ~pm;
                day_adv = pm;
            end
            if (hr_n > H12_LIM) hour_d = FW'(1);
        end
    end

    assign day_wrap = day_n > {1'b0, mlen};
    assign mon_wrap = mon_n > MON_LIM;
    assign yr_wrap  = yr_n > YR_LIM;
    assign day_evt  = hour_inc && day_adv;
    assign mon_evt  = day_evt && day_wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hour <= '0;
            pm   <= 1'b0;
        end else if (wr_hr_u) begin
            hour <= put_units(hour, wdata);
        end else if (wr_hr_t) begin
            hour <= put_tens(hour, wdata);
        end else if (wr_cset) begin
            pm   <= wdata[1] & ~wdata[0];
        end else if (hour_inc) begin
            hour <= hour_d;
            pm   <= pm_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        mode24 <= 1'b0;
        else if (wr_cset)  mode24 <= wdata[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        day <= '0;
        else if (wr_day_u) day <= put_units(day, wdata);
        else if (wr_day_t) day <= put_tens(day, wdata);
        else if (day_evt)  day <= day_wrap ? FW'(1) : day_n[FW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        wday <= '0;
        else if (wr_wday)  wday <= wdata[2:0];
        else if (day_evt)  wday <= (wd_n > WD_LIM) ? 3'd1 : wd_n[2:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        mon <= '0;
        else if (wr_mon_u) mon <= put_units(mon, wdata);
        else if (wr_mon_t) mon <= put_tens(mon, wdata);
        else if (mon_evt)  mon <= mon_wrap ? FW'(1) : mon_n[FW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            year <= '0;
            leap <= '0;
        end else if (wr_yr_u) begin
            year <= put_units(year, wdata);
        end else if (wr_yr_t) begin
            year <= put_tens(year, wdata);
        end else if (wr_cset) begin
            leap <= wdata[3:2];
        end else if (mon_evt && mon_wrap) begin
            year <= yr_wrap ? '0 : yr_n[FW-1:0];
            leap <= leap + 2'd1;
        end
    end

    // R12: PM is never set while the clock is in 24-hour mode
    a_r12_pm_zero_24h: assert property (@(posedge clk) disable iff (!rst_n)
        mode24 |-> !pm);
    // R7: year rollover steps the leap counter by one
    a_r7_leap_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_evt && mon_wrap && !wr_cset) |=> leap == $past(leap) + 2'd1);
    // R5: weekday 7 is followed by 1
    a_r5_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (day_evt && !wr_wday && wday == 3'd7) |=> wday == 3'd1);
    // R6: a day advance never leaves the day above the month length
    a_r6_day_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (day_evt && !wr_day_u && !wr_day_t && !wr_mon_u && !wr_mon_t && !wr_cset && day < mlen)
            |=> day == $past(day) + 8'd1);

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import rtc_pkg::*;
#(
    parameter int HUND_MAX = 99,
    parameter int SEC_MAX  = 59,
    parameter int MIN_MAX  = 59
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_100hz,
    input  logic [IDX_W-1:0]   bus_word,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DIGIT_W-1:0] bus_wdata,
    output logic [DIGIT_W-1:0] bus_rdata
);

    localparam logic [FW:0] HUND_LIM = (FW+1)'(HUND_MAX);
    localparam int NCHAIN = 2;   // seconds, minutes

    logic [NREG-1:0] wr_hit;
    logic            running, advance, rd_ctrl, stop_req, chg_flag;
    logic [FW-1:0]   hund;
    logic [FW:0]     hund_n;
    logic            hund_wrap;
    logic [NCHAIN:0] carry_c;
    logic [FW-1:0]   chain_val [NCHAIN];
    logic [FW-1:0]   hour, day, mon, year;
    logic [2:0]      wday;
    logic            pm, mode24;
    logic [1:0]      leap;

    assign wr_hit   = bus_wr ? (NREG'(1) << bus_word) : '0;
    assign rd_ctrl  = bus_rd && (bus_word == RI_CTRL);
    assign stop_req = bus_wdata[CTL_STOP_BIT];
    assign advance  = running && tick_100hz && !bus_wr;

    rtc_run_fsm u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (wr_hit[RI_CTRL]),
        .stop_req (stop_req),
        .running  (running)
    );

    // hundredths counter and data-changed flag
    assign hund_n    = {1'b0, hund} + (FW+1)'(1);
    assign hund_wrap = advance && (hund_n > HUND_LIM);

    always_ff @(posedge clk) begin
        if (!rst_n)                             hund <= '0;
        else if (wr_hit[RI_CTRL] && stop_req)   hund <= '0;
        else if (wr_hit[RI_TENTHS])             hund <= FW'(bus_wdata) * 8'd10;
        else if (advance)                       hund <= hund_wrap ? '0 : hund_n[FW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         chg_flag <= 1'b0;
        else if (hund_wrap) chg_flag <= 1'b1;
        else if (rd_ctrl)   chg_flag <= 1'b0;
    end

    // seconds and minutes: identical roll-over stages
    assign carry_c[0] = hund_wrap;
    generate
        for (genvar g = 0; g < NCHAIN; g++) begin : g_chain
            localparam int LIMV = (g == 0) ? SEC_MAX : MIN_MAX;
            rtc_wrap_ctr #(.MAX(LIMV)) u_ctr (
                .clk      (clk),
                .rst_n    (rst_n),
                .inc      (carry_c[g]),
                .wr_units (wr_hit[int'(RI_SEC_U) + 2*g]),
                .wr_tens  (wr_hit[int'(RI_SEC_T) + 2*g]),
                .wdigit   (bus_wdata),
                .value    (chain_val[g]),
                .carry    (carry_c[g+1])
            );
        end
    endgenerate

    rtc_calendar u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .hour_inc (carry_c[NCHAIN]),
        .wr_hr_u  (wr_hit[RI_HR_U]),
        .wr_hr_t  (wr_hit[RI_HR_T]),
        .wr_day_u (wr_hit[RI_DAY_U]),
        .wr_day_t (wr_hit[RI_DAY_T]),
        .wr_mon_u (wr_hit[RI_MON_U]),
        .wr_mon_t (wr_hit[RI_MON_T]),
        .wr_yr_u  (wr_hit[RI_YR_U]),
        .wr_yr_t  (wr_hit[RI_YR_T]),
        .wr_wday  (wr_hit[RI_WDAY]),
        .wr_cset  (wr_hit[RI_CSET]),
        .wdata    (bus_wdata),
        .hour     (hour),
        .day      (day),
        .mon      (mon),
        .year     (year),
        .wday     (wday),
        .pm       (pm),
        .mode24   (mode24),
        .leap     (leap)
    );

    // read multiplexer
    always_comb begin
        unique case (bus_word)
            RI_CTRL:   bus_rdata = DIGIT_W'(1 << CTL_CHG_BIT) & {DIGIT_W{chg_flag}};
            RI_TENTHS: bus_rdata = tens_of(hund);
            RI_SEC_U:  bus_rdata = units_of(chain_val[0]);
            RI_SEC_T:  bus_rdata = tens_of(chain_val[0]);
            RI_MIN_U:  bus_rdata = units_of(chain_val[1]);
            RI_MIN_T:  bus_rdata = tens_of(chain_val[1]);
            RI_HR_U:   bus_rdata = units_of(hour);
            RI_HR_T:   bus_rdata = tens_of(hour);
            RI_DAY_U:  bus_rdata = units_of(day);
            RI_DAY_T:  bus_rdata = tens_of(day);
            RI_MON_U:  bus_rdata = units_of(mon);
            RI_MON_T:  bus_rdata = tens_of(mon);
            RI_YR_U:   bus_rdata = units_of(year);
            RI_YR_T:   bus_rdata = tens_of(year);
            RI_WDAY:   bus_rdata = {1'b0, wday};
            RI_CSET:   bus_rdata = {leap, pm, mode24};
        endcase
    end

    // R1: a tick below the limit moves hundredths up by one
    a_r1_hund_step: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && hund < HUND_LIM[FW-1:0]) |=> hund == $past(hund) + 8'd1);
    // R10: reading control/status clears the flag unless it is set that cycle
    a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !hund_wrap) |=> !chg_flag);
    // R11: no counting while halted and not written
    a_r11_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !bus_wr) |=> $stable(hund));
    // R13: a write to another register freezes hundredths for that cycle
    a_r13_write_drops_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !wr_hit[RI_CTRL] && !wr_hit[RI_TENTHS]) |=> $stable(hund));

endmodule

// File: tb/bcd_rtc_tb_top.sv
module bcd_rtc_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_word = 4'd0;
    logic [3:0] bus_wdata = 4'd0;
    logic [3:0] bus_rdata;

    int vec_n = 0;
    int fail_n = 0;
    bit done = 1'b0;

    // reference model state
    int m_h, m_s, m_mi, m_hr, m_d, m_wd, m_mo, m_y, m_lp, m_m24, m_pm, m_flag, m_run;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_rtc dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_100hz (tick),
        .bus_word   (bus_word),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata)
    );

    function automatic int mdays(int mo, int lp);
        if (mo == 2) return (lp == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int set_u(int v, int d);
        return ((v / 10) * 10 + d) % 256;
    endfunction

    function automatic int set_t(int v, int d);
        return (d * 10 + v % 10) % 256;
    endfunction

    task automatic m_write(int idx, int v);
        case (idx)
            0:  if ((v & 4) != 0) begin m_run = 0; m_h = 0; end else m_run = 1; // R11
            1:  m_h = (v & 15) * 10;                                            // R9
            2:  m_s  = set_u(m_s, v);
            3:  m_s  = set_t(m_s, v);
            4:  m_mi = set_u(m_mi, v);
            5:  m_mi = set_t(m_mi, v);
            6:  m_hr = set_u(m_hr, v);
            7:  m_hr = set_t(m_hr, v);
            8:  m_d  = set_u(m_d, v);
            9:  m_d  = set_t(m_d, v);
            10: m_mo = set_u(m_mo, v);
            11: m_mo = set_t(m_mo, v);
            12: m_y  = set_u(m_y, v);
            13: m_y  = set_t(m_y, v);
            14: m_wd = v & 7;                                                   // R5
            default: begin                                                      // R12
                m_m24 = v & 1;
                m_pm  = ((v >> 1) & 1) & (1 - m_m24);
                m_lp  = (v >> 2) & 3;
            end
        endcase
    endtask

    // returns 1 when the hundredths wrapped
    function automatic bit m_tick();
        bit dayadv;
        bit wrapped;
        m_h++;
        if (m_h <= 99) return 1'b0;
        m_h = 0;
        m_s++;
        if (m_s > 59) begin
            m_s = 0;
            m_mi++;
            if (m_mi > 59) begin
                m_mi = 0;
                m_hr++;
                dayadv = 1'b0;
                if (m_m24 != 0) begin
                    if (m_hr > 23) begin m_hr = 0; dayadv = 1'b1; end
                end else begin
                    if (m_hr == 12) begin dayadv = (m_pm != 0); m_pm = 1 - m_pm; end
                    if (m_hr > 12) m_hr = 1;
                end
                if (dayadv) begin
                    m_wd++;
                    if (m_wd > 7) m_wd = 1;
                    m_d++;
                    wrapped = (m_d > mdays(m_mo, m_lp));
                    if (wrapped) begin
                        m_d = 1;
                        m_mo++;
                        if (m_mo > 12) begin
                            m_mo = 1;
                            m_lp = (m_lp + 1) % 4;
                            m_y++;
                            if (m_y > 99) m_y = 0;
                        end
                    end
                end
            end
        end
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_h = 0; m_s = 0; m_mi = 0; m_hr = 0; m_d = 0; m_wd = 0; m_mo = 0;
            m_y = 0; m_lp = 0; m_m24 = 0; m_pm = 0; m_flag = 0; m_run = 1;
        end else if (bus_wr) begin
            m_write(int'(bus_word), int'(bus_wdata));   // R13: no tick this cycle
        end else begin
            bit set_now;
            set_now = 1'b0;
            if (m_run != 0 && tick) set_now = m_tick();
            if (set_now) m_flag = 1;
            else if (bus_rd && bus_word == 4'd0) m_flag = 0;   // R10
        end
    end

    function automatic int exp_read(int idx);
        case (idx)
            0:  return (m_flag != 0) ? 4 : 0;
            1:  return (m_h / 10) & 15;
            2:  return (m_s % 10) & 15;
            3:  return (m_s / 10) & 15;
            4:  return (m_mi % 10) & 15;
            5:  return (m_mi / 10) & 15;
            6:  return (m_hr % 10) & 15;
            7:  return (m_hr / 10) & 15;
            8:  return (m_d % 10) & 15;
            9:  return (m_d / 10) & 15;
            10: return (m_mo % 10) & 15;
            11: return (m_mo / 10) & 15;
            12: return (m_y % 10) & 15;
            13: return (m_y / 10) & 15;
            14: return m_wd & 7;
            default: return (m_lp << 2) | (m_pm << 1) | m_m24;
        endcase
    endfunction

    function automatic string tag_of(int idx);
        case (idx)
            0:  return "R10";
            1:  return "R1";
            2, 3, 4, 5: return "R2";
            6, 7: return "R3/R4";
            8, 9: return "R6";
            10, 11, 12, 13: return "R7";
            14: return "R5";
            default: return "R12";
        endcase
    endfunction

    // R8: every register read is compared with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int e;
            e = exp_read(int'(bus_word));
            vec_n++;
            if (bus_rdata !== 4'(e)) begin
                fail_n++;
                $display("FAIL %s (R8 map) reg %0d actual %0d expected %0d",
                         tag_of(int'(bus_word)), bus_word, bus_rdata, e);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(int idx, int v);
        bus_word  = 4'(idx);
        bus_wdata = 4'(v);
        bus_wr    = 1'b1;
        step();
        bus_wr    = 1'b0;
    endtask

    task automatic sweep();
        for (int i = 0; i < 16; i++) begin
            bus_word = 4'(i);
            bus_rd   = 1'b1;
            step();
        end
        bus_rd = 1'b0;
    endtask

    task automatic run_ticks(int n, int idx);
        bus_word = 4'(idx);
        tick = 1'b1;
        for (int i = 0; i < n; i++) step();
        tick = 1'b0;
    endtask

    // preset to one tenth of a second before the next hour
    task automatic to_hour_edge();
        wr(5, 5); wr(4, 9); wr(3, 5); wr(2, 9); wr(1, 9);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        sweep();                                 // R8: reset values

        run_ticks(150, 1);                       // R1: hundredths count and wrap
        sweep();                                 // R10: flag seen then cleared
        sweep();

        // R3: 12-hour, 11 PM -> 12 AM advances the day, leap Feb 28 -> 29
        wr(15, 2); wr(7, 1); wr(6, 1);
        wr(11, 0); wr(10, 2); wr(9, 2); wr(8, 8); wr(14, 3);
        to_hour_edge();
        run_ticks(10, 6);
        sweep();
        // R3: 11 AM -> 12 PM, no day advance
        wr(15, 0); wr(7, 1); wr(6, 1);
        to_hour_edge();
        run_ticks(10, 8);
        sweep();
        // R3: 12 -> 1
        to_hour_edge();
        run_ticks(10, 6);
        sweep();

        // R4, R6: 24-hour, non-leap Feb 28 23:59 -> Mar 1 00:00
        wr(15, 5); wr(7, 2); wr(6, 3); wr(9, 2); wr(8, 8); wr(11, 0); wr(10, 2);
        to_hour_edge();
        run_ticks(10, 10);
        sweep();

        // R7, R5: Dec 31 year 99 weekday 7 -> Jan 1 year 0, leap 1, weekday 1
        wr(15, 1); wr(7, 2); wr(6, 3); wr(11, 1); wr(10, 2); wr(9, 3); wr(8, 1);
        wr(13, 9); wr(12, 9); wr(14, 7);
        to_hour_edge();
        run_ticks(10, 15);
        sweep();

        // R6: Apr 30 -> May 1
        wr(11, 0); wr(10, 4); wr(9, 3); wr(8, 0); wr(7, 2); wr(6, 3);
        to_hour_edge();
        run_ticks(10, 8);
        sweep();

        // R9: digit writes keep the other digit; weekday keeps low 3 bits
        wr(3, 3); wr(2, 7); wr(2, 5); sweep();
        wr(3, 2); wr(14, 15); wr(1, 4); sweep();

        // R12: PM forced low in 24-hour mode, leap loaded from bits 3:2
        wr(15, 15); sweep();
        wr(15, 10); sweep();

        // R11: stop clears hundredths and ignores ticks, then resume
        run_ticks(25, 1);
        wr(0, 4);
        run_ticks(50, 1);
        sweep();
        wr(0, 0);
        run_ticks(20, 1);
        sweep();

        // R13: writes with the tick held high perform no advance
        tick = 1'b1;
        wr(12, 3); wr(2, 4); wr(14, 2); wr(9, 1);
        tick = 1'b0;
        sweep();

        // long run through hour and day carries in 12-hour mode
        wr(15, 2); wr(7, 1); wr(6, 1); wr(5, 5); wr(4, 8);
        for (int i = 0; i < 40000; i++) begin
            tick     = (i % 3 == 0);
            bus_word = 4'(i % 16);
            bus_rd   = 1'b1;
            step();
        end
        tick = 1'b0;
        bus_rd = 1'b0;
        sweep();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, fail_n);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fail_n++;
            $display("FAIL watchdog: run did not end, actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec_n, fail_n);
            $finish;
        end
    end

endmodule